// File: doc/BRIEF.md
# Indirect Index/Data Register Window

This block reaches a table of 32-bit internal registers through only two bus addresses. Software writes the number of an entry into an index register at address 0. It then reads or writes the data port at address 1, and each such access lands on the entry the index names. A large set of registers therefore costs two words of address space. The price is a second bus access per entry.

The bus is a simple single-cycle interface. A write is taken on the rising clock edge when `bus_sel` and `bus_wr` are both high. Read data is combinational: it is valid in the same cycle as a read request (`bus_sel` high, `bus_wr` low). The table depth and the width of the index register are parameters. The index register may be wider than the table needs, so software can load an index that names no entry.

Top module: `indirect_regfile`

## Requirements
- R1: While `rst_n` is low, and after it is released, the index register reads 0 and every table entry reads 0.
- R2: A write to address 0 loads the index register with `bus_wdata[IDX_W-1:0]`. A read of address 0 returns that value zero-extended to 32 bits.
- R3: A write to address 1 with index < DEPTH stores `bus_wdata` into the entry the index selects. The stored value is visible from the next cycle.
- R4: A read of address 1 with index < DEPTH returns the selected entry in the same cycle.
- R5: With index >= DEPTH, a read of address 1 returns 0 and a write to address 1 changes no table entry.
- R6: Reads and writes of address 1 leave the index register unchanged, so repeated data accesses reach the same entry.
- R7: A read of any address other than 0 and 1 returns 0. A write to such an address changes neither the index nor any entry.
- R8: With `bus_sel` low, `bus_rdata` is 0 and no state changes, whatever `bus_wr`, `bus_addr` and `bus_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address: 0 is the index, 1 is the data port |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data, 0 when nothing is read |

## Verification
The assertions assume that every bus input is known (never X) while `bus_sel` is high. They also assume that a request lasts exactly one clock cycle and that each cycle is a fresh, independent request. The bench meets these conditions by changing every input only on the falling edge and by holding each request for one full cycle. It also drops `bus_sel` between operations. Random index values are drawn from twice the table depth, so in-range and out-of-range accesses both occur often. Random addresses include unmapped ones.

// File: rtl/indirect_regfile.sv
module indirect_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] tab_q [DEPTH];

  wire              at_idx   = bus_sel && (bus_addr == ADDR_W'(0));
  wire              at_dat   = bus_sel && (bus_addr == ADDR_W'(1));
  wire              in_range = 32'(idx_q) < DEPTH;
  wire [SLOT_W-1:0] slot     = idx_q[SLOT_W-1:0];
  wire              dat_wr   = at_dat && bus_wr && in_range;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                idx_q <= '0;
    else if (at_idx && bus_wr) idx_q <= bus_wdata[IDX_W-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                tab_q[g] <= '0;
      else if (dat_wr && slot == SLOT_W'(g))     tab_q[g] <= bus_wdata;
  end

  assign bus_rdata = (at_idx && !bus_wr)             ? {{(DATA_W-IDX_W){1'b0}}, idx_q} :
                     (at_dat && !bus_wr && in_range) ? tab_q[slot] : '0;
endmodule

// File: rtl/indirect_regfile_chk.sv
module indirect_regfile_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [IDX_W-1:0]  idx_q
);
  // R2
  index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(0)) |=> idx_q == $past(bus_wdata[IDX_W-1:0]));

  // R6
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == ADDR_W'(1)) |=> $stable(idx_q));

  // R3
  data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(1) && 32'(idx_q) < DEPTH)
    ##1 (bus_sel && !bus_wr && bus_addr == ADDR_W'(1)) |-> bus_rdata == $past(bus_wdata));

  // R5
  out_of_range_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(1) && 32'(idx_q) >= DEPTH) |-> bus_rdata == '0);

  // R7
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr > ADDR_W'(1)) |-> bus_rdata == '0);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata == '0 ##1 1'b1);

  // R8
  idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> $stable(idx_q));
endmodule

bind indirect_regfile indirect_regfile_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idx_q(idx_q)
);

// File: tb/test_indirect_regfile.sv
module test_indirect_regfile;
  localparam int ADDR_W = 4, DATA_W = 32, DEPTH = 16, IDX_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] m_tab [DEPTH];
  logic [IDX_W-1:0]  m_idx;

  always #4 clk = ~clk;

  indirect_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W))
    i_indirect_regfile (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
                        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
    if (a == 0) return DATA_W'(m_idx);
    if (a == 1) return (32'(m_idx) < DEPTH) ? m_tab[m_idx[3:0]] : '0;
    return '0;
  endfunction

  task automatic model_reset();
    m_idx = '0;
    for (int i = 0; i < DEPTH; i++) m_tab[i] = '0;
  endtask

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (a == 0) m_idx = d[IDX_W-1:0];
    else if (a == 1 && 32'(m_idx) < DEPTH) m_tab[m_idx[3:0]] = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = $urandom;
    #2 check(req, bus_rdata, exp_read(a));
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic scan_all(input string req);
    logic [IDX_W-1:0] keep;
    keep = m_idx;
    for (int i = 0; i < DEPTH; i++) begin
      wr(0, i);
      rd(1, req);
    end
    wr(0, DATA_W'(keep));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    #3 check("R1 rdata during reset", bus_rdata, '0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    rd(0, "R1 index after reset");
    scan_all("R1 entry after reset");

    // R2 / R3 / R4 directed
    wr(0, 32'hFFFF_FF03);
    rd(0, "R2 index readback truncated");
    wr(1, 32'hDEAD_BEEF);
    rd(1, "R3 R4 data readback");
    // R6: repeated data accesses hit the same entry
    wr(1, 32'h1234_5678);
    rd(0, "R6 index after data write");
    rd(1, "R6 same entry rewritten");
    rd(1, "R6 same entry reread");
    wr(0, DEPTH - 1);
    wr(1, 32'hA5A5_0F0F);
    rd(1, "R3 last entry");

    // R5 out of range
    wr(0, DEPTH);
    rd(1, "R5 read at DEPTH");
    wr(1, 32'hBAD0_0001);
    wr(0, 255);
    wr(1, 32'hBAD0_0002);
    rd(1, "R5 read at max index");
    scan_all("R5 table unchanged");

    // R7 unmapped
    wr(5, 32'h0000_0007);
    wr(15, 32'hFFFF_FFFF);
    rd(5, "R7 unmapped read");
    rd(0, "R7 index untouched");
    scan_all("R7 table unchanged");

    // R8 idle bus with write strobe
    wr(0, 2);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 1; bus_wdata = 32'hCAFE_CAFE;
    #2 check("R8 idle rdata", bus_rdata, '0);
    @(negedge clk);
    bus_addr = 0; bus_wdata = 32'h0000_0009;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(0, "R8 index untouched");
    rd(1, "R8 entry untouched");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int unsigned pick = $urandom_range(0, 9);
      logic [ADDR_W-1:0] a;
      a = (pick < 3) ? ADDR_W'(0) : (pick < 9) ? ADDR_W'(1) : ADDR_W'($urandom_range(2, 15));
      if ($urandom_range(0, 1) == 1) begin
        if (a == 0) wr(a, $urandom_range(0, 2 * DEPTH - 1));
        else wr(a, $urandom);
      end else begin
        rd(a, "R4 R5 R6 R7 random read");
      end
    end
    scan_all("R3 random table contents");

    // R1 reset again after traffic
    @(negedge clk) rst_n = 1'b0;
    #2 check("R1 rdata in reset", bus_rdata, '0);
    model_reset();
    @(negedge clk) rst_n = 1'b1;
    rd(0, "R1 index after second reset");
    scan_all("R1 entry after second reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule